// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital side of an 8-bit successive-approximation converter. Software reaches it through one byte-wide control register. That register carries an enable, a done flag that doubles as the interrupt request, a start/busy bit, a converter-clock select and a two-bit channel select. A start command selects one of four analog inputs. The block then walks the eight successive-approximation trials, MSB first, against an external comparator bit. It latches the 8-bit code into a read-only result register and raises the interrupt.

Each conversion is timed in one of two ways. The first uses the CPU clock, where one `clk_i` cycle is one machine cycle. The second uses a separate RC-derived converter clock. On the second path the start request and the completion handshake each cross domains through a two-flop synchronizer. While a conversion runs or an unread completion is pending, the configuration fields are locked and new start commands are dropped. The comparator, the trial DAC and the sample circuit sit outside the block.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control byte reads 00h, the result reads 00h and `irq_o` is 0.
- R2: The control byte fields are: bit 7 enable, bits 6..5 reserved, bit 4 done, bit 3 start/busy, bit 2 clock select (1 = RC clock), bits 1..0 channel. Writes to bits 6..5 are discarded and those bits always read 0.
- R3: A start is accepted when a write sets bit 3 while enable, start and done were all 0 before that write. Start then reads 1 until completion. Done is set on the completion edge, and start clears on the following edge, so the status code with start and done both 1 lasts exactly one cycle.
- R4: A write that sets bit 3 has no effect if, before that write, start was 1, done was 1 or enable was 0. This includes a write that sets enable and start together.
- R5: A write with bit 4 = 0 clears done. A write with bit 4 = 1 never sets it. `irq_o` always equals done.
- R6: A write with bit 7 = 0 leaves enable at 1 when start or done was 1 before the write.
- R7: The clock-select bit and the channel bits take the written value only when start and done were both 0 before the write; otherwise they keep their value.
- R8: `chan_o` presents channel codes 0, 1, 2 and 3 as inputs 0, 1, 2 and 3, and it follows the channel field.
- R9: With clock select 0, done first reads 1 after the 31st rising `clk_i` edge following the edge that accepted the start.
- R10: With clock select 1, the time from the start edge to the first done is at least 106 RC periods. It is at most 114 RC periods plus 8 machine cycles.
- R11: The result is built MSB first, one comparator decision per trial. It is latched on the edge that sets done, so with an ideal comparator it equals the input code. It holds until the next completion.
- R12: When a completion and a software write fall on the same edge, the completion wins. Done is set even if the write clears bit 4, the write's start bit is dropped and the channel and clock fields keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock, one cycle per machine cycle |
| rc_clk_i | input | 1 | RC-derived converter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control-register write strobe |
| wr_data_i | input | 8 | Control-register write data |
| ctrl_o | output | 8 | Control-register read value |
| result_o | output | 8 | Latched conversion result |
| chan_o | output | 2 | Selected analog input |
| dac_o | output | 8 | Trial code for the external DAC |
| cmp_i | input | 1 | Comparator decision (1 = input at or above trial) |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The functions that can coincide are the completion of a conversion and a software write to the control register. The bench provokes this by issuing a CPU-clock start and then counting exactly 30 edges. It places a write that clears done, requests a new start and changes the channel onto the 31st edge, which is the completion edge. The write is judged lost when the control byte shows done and start both set with the old channel after that edge and done with start clear one edge later. No second result may reach the scoreboard.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_EN    = 7;
  localparam int BIT_DONE  = 4;
  localparam int BIT_START = 3;
  localparam int BIT_RC    = 2;
  localparam int CH_W      = 2;
endpackage

// File: rtl/adc_sync2.sv
`timescale 1ns/1ps
module adc_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core #(
  parameter int LEN = 29,
  parameter int W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] code_o,
  output logic         fin_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic          active_q, fin_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sar_q, step_oh;

  // one trial bit per count, MSB first; zero once all bits are decided
  assign step_oh = active_q ? (MSB >> cnt_q) : '0;
  assign trial_o = sar_q | step_oh;
  assign code_o  = sar_q;
  assign fin_o   = fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      cnt_q    <= '0;
      sar_q    <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sar_q    <= '0;
      end else if (active_q) begin
        if (cmp_i) sar_q <= sar_q | step_oh;
        if (cnt_q == CW'(LEN - 1)) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R11
  one_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trial_o ^ sar_q));
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CPU_CYC = 31,
  parameter int RC_LEN  = 106,
  parameter int RES_W   = 8
) (
  input  logic              clk_i,
  input  logic              rc_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [RES_W-1:0]  result_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [RES_W-1:0]  dac_o,
  input  logic              cmp_i,
  output logic              irq_o
);
  // go register and done register take two of the CPU_CYC cycles
  localparam int CPU_LEN = CPU_CYC - 2;
  localparam int LAT_W   = 16;

  logic            en_q, done_q, start_q, rc_q, retire_q;
  logic [CH_W-1:0] chan_q;
  logic [RES_W-1:0] result_q;
  logic            busy_any, accept, cfg_ok, rc_new, fin;
  logic            go_cpu_q, fin_cpu;
  logic [RES_W-1:0] trial_cpu, code_cpu, trial_rc, code_rc;
  logic            run_rc_q, req_q, ack_s, ack_d_q, fin_rc;
  logic            req_rc, req_rc_d_q, go_rc, fin_rc_core, ack_rc_q;

  assign busy_any = start_q | done_q;
  assign cfg_ok   = wr_en_i & ~busy_any;
  assign accept   = wr_en_i & wr_data_i[BIT_START] & en_q & ~busy_any;
  assign rc_new   = cfg_ok ? wr_data_i[BIT_RC] : rc_q;
  assign fin_rc   = ack_s & ~ack_d_q & req_q;
  assign fin      = rc_q ? fin_rc : fin_cpu;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
      rc_q     <= 1'b0;
      chan_q   <= '0;
      retire_q <= 1'b0;
      result_q <= '0;
      go_cpu_q <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wr_data_i[BIT_EN] | (en_q & busy_any);
      if (cfg_ok) begin
        rc_q   <= wr_data_i[BIT_RC];
        chan_q <= wr_data_i[CH_W-1:0];
      end
      if (fin)                                done_q <= 1'b1;
      else if (wr_en_i && !wr_data_i[BIT_DONE]) done_q <= 1'b0;
      if (accept)        start_q <= 1'b1;
      else if (retire_q) start_q <= 1'b0;
      retire_q <= fin;
      if (fin) result_q <= rc_q ? code_rc : code_cpu;
      go_cpu_q <= accept & ~rc_new;
    end
  end

  adc_sar_core #(.LEN(CPU_LEN), .W(RES_W)) u_core_cpu (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_cpu_q), .cmp_i(cmp_i),
    .trial_o(trial_cpu), .code_o(code_cpu), .fin_o(fin_cpu)
  );

  // CPU side of the RC handshake: raise req only after the old ack has dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_rc_q <= 1'b0;
      req_q    <= 1'b0;
      ack_d_q  <= 1'b0;
    end else begin
      ack_d_q <= ack_s;
      if (accept && rc_new) run_rc_q <= 1'b1;
      else if (fin_rc)      run_rc_q <= 1'b0;
      if (fin_rc)                   req_q <= 1'b0;
      else if (run_rc_q && !ack_s)  req_q <= 1'b1;
    end
  end

  adc_sync2 u_sync_req (.clk_i(rc_clk_i), .rst_ni(rst_ni), .d_i(req_q),    .q_o(req_rc));
  adc_sync2 u_sync_ack (.clk_i(clk_i),    .rst_ni(rst_ni), .d_i(ack_rc_q), .q_o(ack_s));

  assign go_rc = req_rc & ~req_rc_d_q;

  always_ff @(posedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_rc_d_q <= 1'b0;
      ack_rc_q   <= 1'b0;
    end else begin
      req_rc_d_q <= req_rc;
      if (!req_rc)          ack_rc_q <= 1'b0;
      else if (fin_rc_core) ack_rc_q <= 1'b1;
    end
  end

  adc_sar_core #(.LEN(RC_LEN), .W(RES_W)) u_core_rc (
    .clk_i(rc_clk_i), .rst_ni(rst_ni), .go_i(go_rc), .cmp_i(cmp_i),
    .trial_o(trial_rc), .code_o(code_rc), .fin_o(fin_rc_core)
  );

  assign ctrl_o   = {en_q, 2'b00, done_q, start_q, rc_q, chan_q};
  assign result_o = result_q;
  assign chan_o   = chan_q;
  assign dac_o    = rc_q ? trial_rc : trial_cpu;
  assign irq_o    = done_q;

  // checker-side latency counter for the CPU-clock path
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (start_q && lat_q != '1) lat_q <= lat_q + 1'b1;
  end

  // R3
  done_with_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> start_q);
  // R3
  status_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |=> !start_q);
  // R3
  stop_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> $past(done_q));
  // R6
  en_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && busy_any) |=> en_q);
  // R7
  chan_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_any |=> $stable(chan_q) && $stable(rc_q));
  // R9
  cpu_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_q) && !rc_q) |-> lat_q == LAT_W'(CPU_CYC));
  // R5
  irq_follows_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ctrl_o[BIT_DONE]);
endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
  localparam real TCPU = 4.0;
  localparam real TRC  = 6.0;

  logic       clk = 0, rc_clk = 0, rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl, result, dac;
  logic [1:0] chan;
  logic       cmp, irq;
  logic [7:0] vin [4];

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];
  realtime t_edge;

  always #(TCPU/2) clk = ~clk;
  always #(TRC/2)  rc_clk = ~rc_clk;

  assign cmp = (dac <= vin[chan]);

  adc_seq_top u_dut (
    .clk_i(clk), .rc_clk_i(rc_clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .result_o(result), .chan_o(chan),
    .dac_o(dac), .cmp_i(cmp), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(posedge clk); t_edge = $realtime;
    @(negedge clk); wr_en = 0;
  endtask

  // monitor: each rising irq pops one expected result
  logic irq_prev = 0;
  always @(negedge clk) begin
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) chk("R4 unexpected completion", 1, 0);
      else chk("R11 result", {24'd0, result}, {24'd0, exp_q.pop_front()});
    end
    irq_prev = irq;
  end

  // CPU-clock conversion with exact latency check; caller is at negedge after start edge
  task automatic cpu_conv(input logic [1:0] ch, input logic [7:0] v);
    int n = 0;
    vin[ch] = v;
    wr(8'h80 | {6'd0, ch});
    exp_q.push_back(v);
    wr(8'h88 | {6'd0, ch});
    chk("R8 chan", {30'd0, chan}, {30'd0, ch});
    while (n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ctrl[4]) break;
    end
    chk("R9 latency", n, 31);
    chk("R3 status both set", {30'd0, ctrl[4:3]}, 32'h3);
    @(negedge clk);
    chk("R3 start cleared", {30'd0, ctrl[4:3]}, 32'h2);
    wr(8'h80 | {6'd0, ch});
    chk("R5 done cleared", {31'd0, irq}, 0);
    chk("R11 result held", {24'd0, result}, {24'd0, v});
  endtask

  task automatic rc_conv(input logic [1:0] ch, input logic [7:0] v);
    realtime dt;
    int n = 0;
    vin[ch] = v;
    wr(8'h84 | {6'd0, ch});
    exp_q.push_back(v);
    wr(8'h8C | {6'd0, ch});
    dt = $realtime;
    dt = t_edge;
    while (n < 400) begin
      @(negedge clk); n++;
      if (ctrl[4]) break;
    end
    dt = $realtime - TCPU/2 - dt;
    chk("R10 min", (dt >= 106*TRC), 1);
    chk("R10 max", (dt <= 114*TRC + 8*TCPU), 1);
    wr(8'h84 | {6'd0, ch});
  endtask

  initial begin
    #(200000 * TCPU);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (vin[i]) vin[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 ctrl", {24'd0, ctrl}, 0);
    chk("R1 result", {24'd0, result}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R4: start while disabled, and start together with enable
    wr(8'h08);
    repeat (40) @(negedge clk);
    chk("R4 start while disabled", {24'd0, ctrl}, 0);
    wr(8'h88);
    repeat (40) @(negedge clk);
    chk("R4 start with enable", {24'd0, ctrl}, 32'h80);
    // R2 reserved bits
    wr(8'h61);
    chk("R2 reserved dropped", {24'd0, ctrl}, 32'h01);
    wr(8'hE0);
    chk("R2 reserved read zero", {24'd0, ctrl}, 32'h80);
    // R5 writing 1 to done does not set it
    wr(8'h90);
    chk("R5 no software set", {24'd0, ctrl}, 32'h80);

    cpu_conv(2'd2, 8'hA5);
    cpu_conv(2'd0, 8'h00);
    cpu_conv(2'd1, 8'hFF);
    cpu_conv(2'd3, 8'h5A);

    // locks while busy: R6, R7
    vin[2] = 8'h3C;
    exp_q.push_back(8'h3C);
    wr(8'h8A);
    wr(8'h05);
    chk("R6 enable held busy", {31'd0, ctrl[7]}, 1);
    chk("R7 chan locked busy", {30'd0, chan}, 2);
    chk("R7 clksel locked busy", {31'd0, ctrl[2]}, 0);
    repeat (40) @(negedge clk);
    chk("R3 done after busy", {24'd0, ctrl}, 32'h92);
    // locks while done: R4, R6, R7
    wr(8'h9F);
    chk("R4 start ignored on done", {24'd0, ctrl}, 32'h92);
    wr(8'h12);
    chk("R6 enable held done", {24'd0, ctrl}, 32'h92);
    repeat (40) @(negedge clk);
    chk("R4 no restart", {24'd0, ctrl}, 32'h92);
    wr(8'h82);
    chk("R5 clear", {24'd0, ctrl}, 32'h82);
    chk("R11 result kept", {24'd0, result}, 32'h3C);

    // R12 collision on completion edge
    vin[2] = 8'h81;
    exp_q.push_back(8'h81);
    wr(8'h8A);
    repeat (30) @(posedge clk);
    @(negedge clk); wr_en = 1; wr_data = 8'h89;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    chk("R12 completion wins", {24'd0, ctrl}, 32'h9A);
    @(negedge clk);
    chk("R12 no restart", {24'd0, ctrl}, 32'h92);
    repeat (40) @(negedge clk);
    chk("R12 still done", {24'd0, ctrl}, 32'h92);
    wr(8'h82);

    // RC-clock path
    rc_conv(2'd1, 8'h6E);
    rc_conv(2'd3, 8'hFE);
    chk("R8 chan rc", {30'd0, chan}, 3);

    repeat (10) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule